// File: doc/BRIEF.md
# Infrared Pulse-Width Capture Receiver

This block times the marks and spaces of a demodulated infrared envelope and queues one record per measured interval in a small receive FIFO. A host drains the FIFO one word at a time through a read strobe. Each word carries the measured count, the level that was measured and a flag that says the word holds fresh data. Widths are counted on a sampling tick strobe at one count per four ticks. A minimum-width filter on the envelope removes short glitches before any edge is detected.

Control inputs choose which envelope edges close one measurement and open the next. They also choose what happens when the width counter runs out, and which FIFO fill level raises a service request. Timeout, overrun, busy and service-request status bits are exported. Timeout, overrun and service request each have an interrupt enable, and the interrupt output combines the enabled ones.

Top module: `ir_pw_capture`

## Requirements
- R1: A read word holds the count in bits CNT_W-1:0, the measured level in bit CNT_W and a valid flag in bit CNT_W+1. With the FIFO empty the whole word reads as zero.
- R2: While a measurement is open the count rises by one for every 4 ticks seen after the opening edge. Ticks in the edge cycle itself are not counted. With a tick on every clock, an interval of L clocks between envelope changes records floor((L-1)/4). With no ticks it records 0.
- R3: The edge select code picks the edges that close and restart a measurement: 00 none, 01 falling, 10 rising, 11 both. The first selected edge after the receiver is enabled opens a measurement and writes no record. Busy is high while a measurement is open. Busy is low while capture is off or the receiver is disabled.
- R4: With a minimum-width count N of 4 or more, an envelope level must hold for N consecutive clocks before it is accepted. A pulse of N-1 clocks is dropped and a pulse of N clocks passes. With N below 4 the filter is bypassed.
- R5: If the count would pass its maximum, the timeout bit sets and the measurement closes with busy low. A marker record of all ones in its low CNT_W+1 bits is written, unless the no-load control is set, in which case nothing is written. The next selected edge reopens a measurement and writes no record.
- R6: The FIFO holds FIFO_DEPTH (8) records and returns them in order of arrival.
- R7: A record arriving when the FIFO is full, with no read in the same cycle, is dropped and sets the overrun bit. Holding the FIFO enable low empties the FIFO and clears overrun.
- R8: Holding the receiver enable low clears the timeout bit.
- R9: With the watermark control set, the service request is high whenever the FIFO holds at least one record. With it clear, the request is high when the FIFO holds FIFO_DEPTH/2 or more.
- R10: The status word is {service, busy, overrun, timeout} in bits 3:0. Enable bits 2:0 gate {service, overrun, timeout}, and the interrupt is the OR of the enabled bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| env_i | input | 1 | Demodulated envelope |
| tick_i | input | 1 | Sampling tick strobe for the width counter |
| rx_en_i | input | 1 | Receiver enable; low clears timeout and closes any measurement |
| fifo_en_i | input | 1 | FIFO enable; low empties the FIFO and clears overrun |
| edge_sel_i | input | 2 | Measurement edge select: 00 off, 01 falling, 10 rising, 11 both |
| no_ovf_load_i | input | 1 | Set: write nothing on counter overflow |
| wm_not_empty_i | input | 1 | Set: service request on not empty; clear: on half full |
| filt_cnt_i | input | FILT_W | Minimum accepted pulse width in clocks |
| irq_en_i | input | 3 | Interrupt enables {service, overrun, timeout} |
| rd_i | input | 1 | Pops the head record |
| rd_data_o | output | CNT_W+2 | {valid, level, count} of the head record |
| stat_o | output | 4 | {service, busy, overrun, timeout} |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check several relations on every cycle. The filter output only ever moves to the level the envelope held one clock before. Busy falls whenever capture is off or the receiver is disabled, and timeout clears under a disabled receiver. A rising timeout comes with busy low and, unless loading is suppressed, a marker write. The FIFO never exceeds its depth, and a write into a full FIFO always leaves overrun set. An invalid read word is always zero. The exact recorded counts cannot be shown by a per-cycle property, and neither can the behaviour of each edge mode, the filter threshold, watermark levels, arrival order or the marker sequence around an overflow. The scoreboard scenarios cover these by comparing every record the block emits against one predicted from the drive pattern.

// File: rtl/ir_cap_pkg.sv
package ir_cap_pkg;
  localparam int unsigned PRESCALE = 4;

  typedef enum logic [1:0] {
    EDG_OFF  = 2'b00,
    EDG_FALL = 2'b01,
    EDG_RISE = 2'b10,
    EDG_BOTH = 2'b11
  } edge_mode_e;

  localparam int ST_TMO = 0;
  localparam int ST_OVR = 1;
  localparam int ST_BSY = 2;
  localparam int ST_SRV = 3;
endpackage

// File: rtl/ir_glitch_filter.sv
module ir_glitch_filter #(
  parameter int FW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          env_i,
  input  logic [FW-1:0] min_cnt_i,
  output logic          flt_o
);
  logic          flt_q;
  logic [FW-1:0] run_q;
  logic          bypass;

  assign bypass = (min_cnt_i < FW'(4));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flt_q <= 1'b0;
      run_q <= '0;
    end else if (bypass || env_i == flt_q) begin
      flt_q <= env_i;
      run_q <= '0;
    end else if (run_q == min_cnt_i - 1'b1) begin
      flt_q <= env_i;
      run_q <= '0;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  assign flt_o = flt_q;

  // R4
  flt_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flt_q != $past(flt_q)) |-> (flt_q == $past(env_i)));
endmodule

// File: rtl/ir_width_timer.sv
module ir_width_timer
  import ir_cap_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        lvl_i,
  input  logic        tick_i,
  input  logic        rx_en_i,
  input  logic [1:0]  edge_sel_i,
  input  logic        no_ovf_load_i,
  output logic        wr_o,
  output logic [CW:0] rec_o,
  output logic        busy_o,
  output logic        tmo_o
);
  localparam int PW = $clog2(PRESCALE);
  localparam logic [PW-1:0] PRE_LAST = PW'(PRESCALE - 1);

  logic          lvl_q, busy_q, tmo_q, wr_q;
  logic [PW-1:0] pre_q;
  logic [CW-1:0] cnt_q;
  logic [CW:0]   rec_q;
  logic          rise, fall, hit;

  assign rise = lvl_i & ~lvl_q;
  assign fall = ~lvl_i & lvl_q;
  assign hit  = rx_en_i & ((edge_sel_i[1] & rise) | (edge_sel_i[0] & fall));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      tmo_q  <= 1'b0;
      wr_q   <= 1'b0;
      pre_q  <= '0;
      cnt_q  <= '0;
      rec_q  <= '0;
    end else begin
      wr_q <= 1'b0;
      if (!rx_en_i) begin
        busy_q <= 1'b0;
        tmo_q  <= 1'b0;
      end else if (edge_sel_i == EDG_OFF) begin
        busy_q <= 1'b0;
      end else if (hit) begin
        if (busy_q) begin
          wr_q  <= 1'b1;
          rec_q <= {lvl_q, cnt_q};
        end
        busy_q <= 1'b1;
        pre_q  <= '0;
        cnt_q  <= '0;
      end else if (busy_q && tick_i) begin
        if (pre_q == PRE_LAST) begin
          pre_q <= '0;
          if (cnt_q == '1) begin
            busy_q <= 1'b0;
            tmo_q  <= 1'b1;
            if (!no_ovf_load_i) begin
              wr_q  <= 1'b1;
              rec_q <= '1;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end else begin
          pre_q <= pre_q + 1'b1;
        end
      end
    end
  end

  assign wr_o   = wr_q;
  assign rec_o  = rec_q;
  assign busy_o = busy_q;
  assign tmo_o  = tmo_q;

  // R3
  busy_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_en_i || edge_sel_i == EDG_OFF) |=> !busy_q);
  // R8
  tmo_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |=> !tmo_q);
  // R5
  tmo_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tmo_q) |-> !busy_q);
  // R5
  tmo_marker_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(tmo_q) && !$past(no_ovf_load_i)) |-> (wr_q && rec_q == '1));
endmodule

// File: rtl/ir_rx_fifo.sv
module ir_rx_fifo #(
  parameter int DW    = 17,
  parameter int DEPTH = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_i,
  output logic [DW-1:0] rdata_o,
  output logic          empty_o,
  output logic [$clog2(DEPTH+1)-1:0] level_o,
  output logic          ovr_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [LW-1:0] cnt_q;
  logic          ovr_q, do_wr, do_rd;

  assign do_rd = en_i & rd_i & (cnt_q != '0);
  assign do_wr = en_i & wr_i & ((cnt_q != LW'(DEPTH)) | do_rd);

  always_ff @(posedge clk_i) begin
    if (do_wr) mem_q[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      ovr_q <= 1'b0;
    end else if (!en_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      if (do_wr) wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (do_rd) rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      cnt_q <= cnt_q + LW'(do_wr) - LW'(do_rd);
      if (wr_i && !do_wr) ovr_q <= 1'b1;
    end
  end

  assign rdata_o = mem_q[rp_q];
  assign empty_o = (cnt_q == '0);
  assign level_o = cnt_q;
  assign ovr_o   = ovr_q;

  // R6
  depth_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LW'(DEPTH));
  // R7
  overrun_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && wr_i && !rd_i && cnt_q == LW'(DEPTH)) |=> ovr_q);
  // R7
  flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!ovr_q && cnt_q == '0));
endmodule

// File: rtl/ir_pw_capture.sv
module ir_pw_capture
  import ir_cap_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int FIFO_DEPTH = 8,
  parameter int FILT_W     = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              env_i,
  input  logic              tick_i,
  input  logic              rx_en_i,
  input  logic              fifo_en_i,
  input  logic [1:0]        edge_sel_i,
  input  logic              no_ovf_load_i,
  input  logic              wm_not_empty_i,
  input  logic [FILT_W-1:0] filt_cnt_i,
  input  logic [2:0]        irq_en_i,
  input  logic              rd_i,
  output logic [CNT_W+1:0]  rd_data_o,
  output logic [3:0]        stat_o,
  output logic              irq_o
);
  localparam int DW   = CNT_W + 1;
  localparam int LW   = $clog2(FIFO_DEPTH + 1);
  localparam int HALF = FIFO_DEPTH / 2;
  localparam int VB   = CNT_W + 1;

  logic          flt, wr, busy, tmo, ovr, empty, srv;
  logic [DW-1:0] rec, head;
  logic [LW-1:0] level;

  ir_glitch_filter #(.FW(FILT_W)) u_flt (
    .clk_i, .rst_ni, .env_i, .min_cnt_i(filt_cnt_i), .flt_o(flt)
  );

  ir_width_timer #(.CW(CNT_W)) u_tmr (
    .clk_i, .rst_ni, .lvl_i(flt), .tick_i, .rx_en_i, .edge_sel_i,
    .no_ovf_load_i, .wr_o(wr), .rec_o(rec), .busy_o(busy), .tmo_o(tmo)
  );

  ir_rx_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i, .rst_ni, .en_i(fifo_en_i), .wr_i(wr), .wdata_i(rec), .rd_i,
    .rdata_o(head), .empty_o(empty), .level_o(level), .ovr_o(ovr)
  );

  assign srv       = wm_not_empty_i ? !empty : (level >= LW'(HALF));
  assign rd_data_o = empty ? '0 : {1'b1, head};
  assign stat_o    = {srv, busy, ovr, tmo};
  assign irq_o     = |(irq_en_i & {srv, ovr, tmo});

  // R1
  empty_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_data_o[VB] |-> (rd_data_o == '0));
  // R9
  wm_ne_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wm_not_empty_i && rd_data_o[VB]) |-> stat_o[ST_SRV]);
  // R10
  irq_ovr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_en_i[1] && stat_o[ST_OVR]) |-> irq_o);
endmodule

// File: tb/sim_ir_pw_capture.sv
module sim_ir_pw_capture;
  localparam int CW  = 8;
  localparam int LIM = 4 * (1 << CW);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic env_i = 1'b0, tick_i = 1'b1, rx_en_i = 1'b0, fifo_en_i = 1'b1;
  logic [1:0] edge_sel_i = 2'b11;
  logic no_ovf_load_i = 1'b0, wm_not_empty_i = 1'b0;
  logic [15:0] filt_cnt_i = '0;
  logic [2:0] irq_en_i = '0;
  logic rd_i;
  logic [CW+1:0] rd_data_o;
  logic [3:0] stat_o;
  logic irq_o;

  always #4 clk = ~clk;

  ir_pw_capture #(.CNT_W(CW)) u0 (
    .clk_i(clk), .rst_ni, .env_i, .tick_i, .rx_en_i, .fifo_en_i, .edge_sel_i,
    .no_ovf_load_i, .wm_not_empty_i, .filt_cnt_i, .irq_en_i, .rd_i,
    .rd_data_o, .stat_o, .irq_o
  );

  int checks = 0, fails = 0;
  logic [CW+1:0] exp_q[$];
  bit mon_en = 0, armed = 0, tick_on = 1;
  int span = 0, push_left = 1000000;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // scoreboard monitor
  initial begin
    rd_i = 1'b0;
    forever begin
      @(negedge clk);
      rd_i = 1'b0;
      if (mon_en && rd_data_o[CW+1]) begin
        if (exp_q.size() == 0) check("R2 unexpected record", 32'(rd_data_o), 0);
        else check("R1 R2 R5 R6 record", 32'(rd_data_o), 32'(exp_q.pop_front()));
        rd_i = 1'b1;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=running exp=done");
    report();
  end

  task automatic push_exp(logic [CW+1:0] w);
    if (push_left > 0) begin
      exp_q.push_back(w);
      push_left--;
    end
  endtask

  // driver: hold envelope at lvl for len clocks, predicting records
  task automatic drive(input logic lvl, input int len);
    if (lvl !== env_i && rx_en_i &&
        ((lvl && edge_sel_i[1]) || (!lvl && edge_sel_i[0]))) begin
      if (armed) push_exp({1'b1, env_i, CW'(tick_on ? (span - 1) / 4 : 0)});
      armed = 1;
      span = 0;
    end
    env_i = lvl;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      span++;
      if (armed && tick_on && span - 1 >= LIM) begin
        if (!no_ovf_load_i) push_exp('1);
        armed = 0;
      end
    end
  endtask

  task automatic glitch(input int len);
    env_i = ~env_i;
    for (int i = 0; i < len; i++) begin @(negedge clk); span++; end
    env_i = ~env_i;
  endtask

  task automatic cfg(logic [1:0] es, logic [15:0] fc, logic nol, logic wm);
    rx_en_i = 1'b0;
    edge_sel_i = es; filt_cnt_i = fc; no_ovf_load_i = nol; wm_not_empty_i = wm;
    repeat (2) @(negedge clk);
    rx_en_i = 1'b1;
    armed = 0; span = 0;
    @(negedge clk);
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset read word", 32'(rd_data_o), 0);
    check("R10 reset status", 32'(stat_o), 0);
    check("R10 reset irq", 32'(irq_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // both edges, assorted widths
    cfg(2'b11, 16'd0, 1'b0, 1'b0);
    mon_en = 1;
    drive(0, 10); drive(1, 9);
    check("R3 busy after opening edge", 32'(stat_o[2]), 1);
    drive(0, 13); drive(1, 4); drive(0, 5); drive(1, 21); drive(0, 30); drive(1, 2); drive(0, 10);
    settle(10);
    check("R2 both-edge queue drained", exp_q.size(), 0);

    // falling only
    cfg(2'b01, 16'd0, 1'b0, 1'b0);
    drive(1, 10); drive(0, 10); drive(1, 14); drive(0, 10); drive(1, 7); drive(0, 6); drive(1, 9);
    settle(10);
    check("R3 falling-edge queue drained", exp_q.size(), 0);

    // rising only
    cfg(2'b10, 16'd0, 1'b0, 1'b0);
    drive(0, 10); drive(1, 10); drive(0, 18); drive(1, 6); drive(0, 3); drive(1, 12); drive(0, 8);
    settle(10);
    check("R3 rising-edge queue drained", exp_q.size(), 0);

    // capture off
    cfg(2'b00, 16'd0, 1'b0, 1'b0);
    drive(1, 10); drive(0, 10); drive(1, 10); drive(0, 10);
    check("R3 busy low with capture off", 32'(stat_o[2]), 0);
    check("R3 no record with capture off", 32'(rd_data_o), 0);

    // no ticks
    cfg(2'b11, 16'd0, 1'b0, 1'b0);
    tick_on = 0; tick_i = 1'b0;
    drive(1, 30); drive(0, 40); drive(1, 25);
    settle(10);
    check("R2 tickless queue drained", exp_q.size(), 0);
    tick_on = 1; tick_i = 1'b1;

    // glitch filter at 12 clocks
    cfg(2'b11, 16'd12, 1'b0, 1'b0);
    drive(0, 40); drive(1, 30); drive(0, 40); glitch(11); drive(0, 20);
    drive(1, 12); drive(0, 30); drive(1, 20);
    settle(20);
    check("R4 filtered queue drained", exp_q.size(), 0);
    // filter bypassed below 4
    cfg(2'b11, 16'd3, 1'b0, 1'b0);
    drive(0, 20); drive(1, 20); drive(0, 20); drive(1, 2); drive(0, 20); drive(1, 10);
    settle(10);
    check("R4 bypass short pulse recorded", exp_q.size(), 0);

    // timeout with marker
    cfg(2'b11, 16'd0, 1'b0, 1'b0);
    irq_en_i = 3'b001;
    drive(0, 10); drive(1, 8); drive(0, 1100);
    check("R5 timeout set", 32'(stat_o[0]), 1);
    check("R5 busy low after timeout", 32'(stat_o[2]), 0);
    check("R10 timeout irq", 32'(irq_o), 1);
    irq_en_i = 3'b000;
    @(negedge clk);
    check("R10 irq masked", 32'(irq_o), 0);
    drive(1, 20); drive(0, 20);
    settle(10);
    check("R5 marker and reopen queue drained", exp_q.size(), 0);
    rx_en_i = 1'b0; @(negedge clk); rx_en_i = 1'b1; @(negedge clk);
    armed = 0; span = 0;
    check("R8 timeout cleared", 32'(stat_o[0]), 0);

    // timeout with nothing loaded
    cfg(2'b11, 16'd0, 1'b1, 1'b0);
    drive(1, 8); drive(0, 1100);
    settle(10);
    check("R5 timeout set without marker", 32'(stat_o[0]), 1);
    check("R5 no marker queued", exp_q.size(), 0);
    check("R5 no marker in FIFO", 32'(rd_data_o), 0);

    // watermark half, overrun, order
    cfg(2'b11, 16'd0, 1'b0, 1'b0);
    mon_en = 0; push_left = 8; irq_en_i = 3'b100;
    drive(1, 8);
    for (int i = 0; i < 3; i++) drive(~env_i, 8);
    check("R9 three records below half", 32'(stat_o[3]), 0);
    check("R10 service irq low", 32'(irq_o), 0);
    drive(~env_i, 8);
    check("R9 four records at half", 32'(stat_o[3]), 1);
    check("R10 service irq high", 32'(irq_o), 1);
    for (int i = 0; i < 6; i++) drive(~env_i, 8);
    check("R7 overrun after ten records", 32'(stat_o[1]), 1);
    check("R3 busy while open", 32'(stat_o[2]), 1);
    irq_en_i = 3'b010;
    @(negedge clk);
    check("R10 overrun irq", 32'(irq_o), 1);
    mon_en = 1;
    settle(30);
    check("R6 eight records in order", exp_q.size(), 0);
    check("R1 empty read is zero", 32'(rd_data_o), 0);
    check("R7 overrun held until cleared", 32'(stat_o[1]), 1);
    fifo_en_i = 1'b0; @(negedge clk); fifo_en_i = 1'b1; @(negedge clk);
    check("R7 overrun cleared", 32'(stat_o[1]), 0);
    push_left = 1000000; irq_en_i = 3'b000;

    // not-empty watermark and flush
    cfg(2'b11, 16'd0, 1'b0, 1'b1);
    mon_en = 0;
    drive(~env_i, 8); drive(~env_i, 8);
    check("R9 not-empty request", 32'(stat_o[3]), 1);
    fifo_en_i = 1'b0; @(negedge clk); fifo_en_i = 1'b1; @(negedge clk);
    exp_q.delete();
    check("R7 flush empties FIFO", 32'(rd_data_o), 0);
    check("R9 request drops after flush", 32'(stat_o[3]), 0);
    mon_en = 1;
    settle(10);
    check("R6 final queue empty", exp_q.size(), 0);
    report();
  end
endmodule